// File: doc/BRIEF.md
# Reference Selection and Mode Controller

This block supervises a timing synchronizer that has two reference clocks, a primary and a secondary. A reference-select pin picks the reference that feeds the downstream loop. A mode-select pin asks for tracking (normal) or free-running operation. The controller drives three outputs: the reference multiplexer select, a one-frame enable for the phase-error corrector, and the state select of the phase-locked loop. All of its state changes happen on the rising edge of the 8 kHz frame pulse.

A built-in impairment monitor watches only the reference that is currently selected. The reference is sampled in the master-clock domain. The monitor counts its rising edges over a fixed window of master-clock cycles. It flags an impairment when a window holds too few or too many edges. It also flags an impairment when no edge arrives for a set number of cycles, without waiting for the window to end. While the flag is set, the loop is held in free run even when the mode pin asks for normal operation. The flag clears only after two good windows in a row. The loop then returns to normal at the next frame edge, with no action on the pins. The two control pins pass through two-flop synchronizers before they are sampled.

Top module: `ref_mode_ctrl`

## Requirements
- R1: `muxSel` selects the primary reference (0) when `refSelPin` is 0 and the secondary reference (1) when `refSelPin` is 1. The value applied is the one sampled at a frame-pulse edge.
- R2: When `modeSelPin` is 1, `freeRun` is 1 after the next frame-pulse edge. When `modeSelPin` is 0 and there is no impairment, `freeRun` is 0 after the next frame-pulse edge.
- R3: `muxSel`, `corrEn` and `freeRun` change only in the cycle after a rising edge of `framePulse`. A change on a pin between frame edges has no effect on the outputs until the next edge.
- R4: If the selected reference shows no rising edge for `LOS_CYCLES` master cycles, an impairment is flagged. `freeRun` is then 1 after the next frame edge, whatever the value of `modeSelPin`.
- R5: A window of `WIN_CYCLES` master cycles that holds more than `MAX_EDGES` reference edges flags an impairment.
- R6: A window that holds fewer than `MIN_EDGES` reference edges flags an impairment, even when no loss of signal occurs.
- R7: The impairment clears only at the end of the second good window in a row. Normal mode then resumes at the next frame edge without any change on the pins.
- R8: A frame edge that changes the selected reference sets `corrEn` to 1 for exactly one frame period. The next frame edge without a change sets it back to 0.
- R9: A frame edge that moves the loop from free run to normal sets `corrEn` to 1 for exactly one frame period.
- R10: After reset, `freeRun`=1, `muxSel`=0, `corrEn`=0, and the monitor reports an impairment until it has seen two good windows.
- R11: Only the selected reference is monitored. Loss of the reference that is not selected leaves `freeRun` at 0.
- R12: Entering free run, whether requested by the pin or forced by an impairment, leaves `corrEn` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refPri | input | 1 | Primary reference clock (slow relative to clk) |
| refSec | input | 1 | Secondary reference clock |
| framePulse | input | 1 | 8 kHz frame pulse, in the clk domain |
| refSelPin | input | 1 | Reference request: 0 primary, 1 secondary |
| modeSelPin | input | 1 | Mode request: 0 normal, 1 free run |
| muxSel | output | 1 | Reference multiplexer select |
| corrEn | output | 1 | Phase-error corrector enable |
| freeRun | output | 1 | Loop state select: 1 free run, 0 tracking |

## Verification
Some behaviours are checked by assertions on every cycle. These are: outputs stay frozen between frame edges, an impairment or a free-run request forces free run at the edge, a reference switch raises the corrector enable, and loss of signal or a bad window sets the impairment flag. The flag may only fall at the end of a window. Other behaviours can only be shown by the bench scenarios. These include the full recovery sequence through two good windows and the end of the corrector pulse one frame later. They also include the fact that loss of the idle reference goes unnoticed, and the reset-time path into normal mode.

// File: rtl/refctl_pkg.sv
package refctl_pkg;
  // Strobes from the control FSM to the monitor datapath
  typedef struct packed {
    logic useSec;   // monitor the secondary reference
    logic restart;  // selected reference is switching: restart measurement
  } monCtl_t;
endpackage

// File: rtl/ref_monitor.sv
module ref_monitor
  import refctl_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_EDGES  = 6,
  parameter int MAX_EDGES  = 10,
  parameter int LOS_CYCLES = 24
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    refPri,
  input  logic    refSec,
  input  monCtl_t ctl,
  output logic    impaired
);
  localparam int WW = $clog2(WIN_CYCLES);
  localparam int EW = $clog2(WIN_CYCLES + 2);
  localparam int LW = $clog2(LOS_CYCLES);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [EW-1:0] MIN_E    = EW'(MIN_EDGES);
  localparam logic [EW-1:0] MAX_E    = EW'(MAX_EDGES);
  localparam logic [LW-1:0] LOS_LAST = LW'(LOS_CYCLES - 1);

  logic [2:0]    refSync;
  logic          refEdge;
  logic [WW-1:0] winCnt;
  logic [EW-1:0] edgeCnt, edgeTotal;
  logic [LW-1:0] losCnt;
  logic [1:0]    goodRun;
  logic          winEnd, windowGood, losHit;

  wire refRaw = ctl.useSec ? refSec : refPri;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refSync <= '0;
    else        refSync <= {refSync[1:0], refRaw};
  end

  assign refEdge    = refSync[1] & ~refSync[2];
  assign winEnd     = (winCnt == WIN_LAST);
  assign edgeTotal  = edgeCnt + EW'(refEdge);
  assign windowGood = (edgeTotal >= MIN_E) && (edgeTotal <= MAX_E);
  assign losHit     = !refEdge && (losCnt == LOS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt  <= '0;
      edgeCnt <= '0;
      losCnt  <= '0;
    end else if (ctl.restart) begin
      winCnt  <= '0;
      edgeCnt <= '0;
      losCnt  <= '0;
    end else begin
      winCnt  <= winEnd ? '0 : winCnt + 1'b1;
      edgeCnt <= winEnd ? '0 : edgeTotal;
      if (refEdge)     losCnt <= '0;
      else if (!losHit) losCnt <= losCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      impaired <= 1'b1;
      goodRun  <= '0;
    end else if (!ctl.restart) begin
      if (losHit || (winEnd && !windowGood)) begin
        impaired <= 1'b1;
        goodRun  <= '0;
      end else if (winEnd) begin
        if (goodRun != 2'd2) goodRun <= goodRun + 1'b1;
        if (goodRun != 2'd0) impaired <= 1'b0;
      end
    end
  end

  // R4: loss of signal raises the impairment flag
  p_los_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (losHit && !ctl.restart) |=> impaired);
  // R5 / R6: a window outside the edge-count bounds raises the flag
  p_bad_window_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (winEnd && !windowGood && !ctl.restart) |=> impaired);
  // R7: the flag may only clear at the end of a window
  p_clear_at_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(impaired) |-> $past(winEnd));
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import refctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    refSelPin,
  input  logic    modeSelPin,
  input  logic    framePulse,
  input  logic    impaired,
  output monCtl_t ctl,
  output logic    muxSel,
  output logic    corrEn,
  output logic    freeRun
);
  logic [1:0] selSync, modeSync;
  logic       fpPrev, fpEdge;
  logic       selQ, freeRunQ, corrEnQ;
  logic       nextFreeRun, selChange;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selSync  <= '0;
      modeSync <= 2'b11;
      fpPrev   <= 1'b0;
    end else begin
      selSync  <= {selSync[0], refSelPin};
      modeSync <= {modeSync[0], modeSelPin};
      fpPrev   <= framePulse;
    end
  end

  assign fpEdge      = framePulse & ~fpPrev;
  assign nextFreeRun = modeSync[1] | impaired;
  assign selChange   = selSync[1] ^ selQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selQ     <= 1'b0;
      freeRunQ <= 1'b1;
      corrEnQ  <= 1'b0;
    end else if (fpEdge) begin
      selQ     <= selSync[1];
      freeRunQ <= nextFreeRun;
      corrEnQ  <= selChange | (freeRunQ & ~nextFreeRun);
    end
  end

  assign ctl.useSec  = selQ;
  assign ctl.restart = fpEdge & selChange;
  assign muxSel  = selQ;
  assign corrEn  = corrEnQ;
  assign freeRun = freeRunQ;

  // R3: outputs frozen between frame edges
  p_hold_between_frames_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fpEdge |=> $stable({muxSel, corrEn, freeRun}));
  // R4: an impairment at a frame edge forces free run
  p_impaired_freerun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fpEdge && impaired) |=> freeRun);
  // R2: a free-run request is honoured at the frame edge
  p_mode_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fpEdge && modeSync[1]) |=> freeRun);
  // R8: a reference switch raises the corrector enable
  p_corr_on_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fpEdge && selChange) |=> (corrEn && muxSel == $past(selSync[1])));
  // R12: entering free run never raises the corrector enable by itself
  p_no_corr_to_freerun_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fpEdge && !selChange && nextFreeRun) |=> !corrEn);
endmodule

// File: rtl/ref_mode_ctrl.sv
module ref_mode_ctrl
  import refctl_pkg::*;
#(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_EDGES  = 6,
  parameter int MAX_EDGES  = 10,
  parameter int LOS_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refPri,
  input  logic refSec,
  input  logic framePulse,
  input  logic refSelPin,
  input  logic modeSelPin,
  output logic muxSel,
  output logic corrEn,
  output logic freeRun
);
  monCtl_t monCtl;
  logic    impaired;

  mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .refSelPin  (refSelPin),
    .modeSelPin (modeSelPin),
    .framePulse (framePulse),
    .impaired   (impaired),
    .ctl        (monCtl),
    .muxSel     (muxSel),
    .corrEn     (corrEn),
    .freeRun    (freeRun)
  );

  ref_monitor #(
    .WIN_CYCLES (WIN_CYCLES),
    .MIN_EDGES  (MIN_EDGES),
    .MAX_EDGES  (MAX_EDGES),
    .LOS_CYCLES (LOS_CYCLES)
  ) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .refPri   (refPri),
    .refSec   (refSec),
    .ctl      (monCtl),
    .impaired (impaired)
  );
endmodule

// File: tb/ref_mode_ctrl_tb.sv
module ref_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refPri = 1'b0, refSec = 1'b0;
  logic framePulse = 1'b0, refSelPin = 1'b0, modeSelPin = 1'b0;
  logic muxSel, corrEn, freeRun;

  int checks = 0, fails = 0, tick = 0;
  int perPri = 8, perSec = 8;   // 8 cycles -> 8 edges per 64-cycle window

  always #4 clk = ~clk;  // 125 MHz

  ref_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .refPri(refPri), .refSec(refSec),
    .framePulse(framePulse), .refSelPin(refSelPin), .modeSelPin(modeSelPin),
    .muxSel(muxSel), .corrEn(corrEn), .freeRun(freeRun)
  );

  always @(negedge clk) begin
    tick   <= tick + 1;
    refPri <= (perPri != 0) && ((tick % (perPri == 0 ? 1 : perPri)) < perPri / 2);
    refSec <= (perSec != 0) && ((tick % (perSec == 0 ? 1 : perSec)) < perSec / 2);
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    @(negedge clk) framePulse = 1'b1;
    @(negedge clk) framePulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 freeRun after reset", freeRun, 1'b1);
    check("R10 muxSel after reset", muxSel, 1'b0);
    check("R10 corrEn after reset", corrEn, 1'b0);
    frame();  // monitor has not yet seen two good windows
    check("R10 impaired until two windows", freeRun, 1'b1);
  endtask

  task automatic t_startup();
    waitCycles(260);
    frame();
    check("R2 normal on mode 0", freeRun, 1'b0);
    check("R9 corrEn on entry to normal", corrEn, 1'b1);
    frame();
    check("R9 corrEn one frame only", corrEn, 1'b0);
  endtask

  task automatic t_switch();
    refSelPin = 1'b1;
    waitCycles(20);
    check("R3 muxSel held without frame", muxSel, 1'b0);
    check("R3 corrEn held without frame", corrEn, 1'b0);
    frame();
    check("R1 secondary selected", muxSel, 1'b1);
    check("R8 corrEn on switch", corrEn, 1'b1);
    frame();
    check("R8 corrEn drops next frame", corrEn, 1'b0);
    check("R2 still tracking", freeRun, 1'b0);
    refSelPin = 1'b0;
    waitCycles(5);
    frame();
    check("R1 primary selected", muxSel, 1'b0);
    check("R8 corrEn on switch back", corrEn, 1'b1);
    frame();
    check("R8 corrEn drops again", corrEn, 1'b0);
  endtask

  task automatic recover(input string req);
    waitCycles(2);
    frame();
    check({req, " still free run right after restore"}, freeRun, 1'b1);
    waitCycles(260);
    frame();
    check({req, " automatic return to normal"}, freeRun, 1'b0);
    check("R9 corrEn on recovery", corrEn, 1'b1);
    frame();
  endtask

  task automatic t_los();
    perPri = 0;
    waitCycles(60);
    frame();
    check("R4 free run on loss", freeRun, 1'b1);
    check("R12 no corrEn on forced free run", corrEn, 1'b0);
    perPri = 8;
    recover("R7");
  endtask

  task automatic t_fast();
    perPri = 4;
    waitCycles(150);
    frame();
    check("R5 free run on too many edges", freeRun, 1'b1);
    perPri = 8;
    recover("R5");
  endtask

  task automatic t_slow();
    perPri = 20;
    waitCycles(150);
    frame();
    check("R6 free run on too few edges", freeRun, 1'b1);
    perPri = 8;
    recover("R6");
  endtask

  task automatic t_mode();
    modeSelPin = 1'b1;
    waitCycles(5);
    frame();
    check("R2 free run on request", freeRun, 1'b1);
    check("R12 no corrEn on requested free run", corrEn, 1'b0);
    modeSelPin = 1'b0;
    waitCycles(5);
    frame();
    check("R2 normal on release", freeRun, 1'b0);
    check("R9 corrEn on return", corrEn, 1'b1);
    frame();
  endtask

  task automatic t_idle_ref();
    perSec = 0;
    waitCycles(150);
    frame();
    check("R11 idle reference loss ignored", freeRun, 1'b0);
    check("R11 selection unchanged", muxSel, 1'b0);
    perSec = 8;
  endtask

  initial begin
    waitCycles(3);
    rst_n = 1'b1;
    waitCycles(1);
    t_reset();
    t_startup();
    t_switch();
    t_los();
    t_fast();
    t_slow();
    t_mode();
    t_idle_ref();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule